// File: doc/BRIEF.md
# Mixed-Mode Element Instruction Sequencer

This block is the control slice that sits in front of every processing element of a mixed-mode array and decides, one instruction at a time, where that element's next instruction comes from. In lockstep (SIMD) mode the element listens to a stream that a global controller broadcasts from a shared program store. It executes only the words whose cluster tag equals its own cluster number. In independent (MIMD) mode it ignores the broadcast and walks its own local program store with a private program counter. It follows jumps and parks itself on a system-control instruction, raising a done flag towards the global controller.

The global controller rewrites each element's mode and cluster number with a configure command. The command carries an element index and can also be sent to all elements at once. A switch to independent mode also loads a start address into the local counter. Because every element keeps its own mode and cluster number, one array can run several lockstep clusters and several independent elements side by side. The issued instruction leaves the block one cycle after it is selected, tagged with its source. Instruction groups are decoded from the top three bits of the word.

Top module: `elem_seq_top`

## Requirements
- R1: After reset the element is in lockstep mode with cluster number 0, the done flag is low, no instruction is issued and the local store is not read.
- R2: In lockstep mode, a broadcast word whose cluster tag equals the element's cluster number is issued on the next cycle with the source flag low.
- R3: A broadcast word is ignored, with nothing issued from it, when its tag differs from the element's cluster number or when the element is in independent mode.
- R4: In independent mode with done low, the local store is read at the program counter (read enable high). The word read is issued on the next cycle with the source flag high. The counter then advances by one.
- R5: A local word whose top three bits are 3'b011 is a jump: the next counter value is its low PC_W bits.
- R6: A local word whose top three bits are 3'b111 is system control. It is issued, the done flag rises on the next cycle, and from then on no local read and no issue happen until a configure command reaches the element.
- R7: A configure command takes effect only when its element index equals the element's own index, unless it is the all-elements form. Otherwise mode and cluster number stay unchanged.
- R8: A configure command in the all-elements form takes effect whatever its index field holds.
- R9: A configure command that selects independent mode loads its start address into the program counter and clears the done flag. The first local read happens on the next cycle at that address.
- R10: A configure command that selects lockstep mode lets the instruction chosen in that same cycle still issue from the old source. From the next cycle on, local reads stop.
- R11: A configure command that reaches the element loads its cluster number into the element, and the new value is used for tag matching from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Configure command present |
| cfgAll | input | 1 | Command applies to all elements |
| cfgTarget | input | IDX_W | Element index the command addresses |
| cfgMimd | input | 1 | 1 selects independent mode, 0 lockstep |
| cfgCluster | input | CL_W | Cluster number to load |
| cfgStart | input | PC_W | Local start address for independent mode |
| bcValid | input | 1 | Broadcast word present |
| bcCluster | input | CL_W | Cluster tag of the broadcast word |
| bcInstr | input | INSTR_W | Broadcast instruction word |
| lpmAddr | output | PC_W | Local program store address (program counter) |
| lpmRdEn | output | 1 | Local program store read enable |
| lpmData | input | INSTR_W | Local program store read data, same cycle |
| issueValid | output | 1 | Instruction issued this cycle |
| issueInstr | output | INSTR_W | Issued instruction word (zero when none) |
| issueLocal | output | 1 | 1 when the issued word came from local store |
| doneFlag | output | 1 | Element has parked on a system-control word |
| modeMimd | output | 1 | Current mode, 1 independent |
| clusterId | output | CL_W | Current cluster number |

## Verification
The bench builds the element as index 5 with a 4-bit index field, 3-bit cluster numbers and a 6-bit program counter. With these values, misaddressed configure commands (index 7) can be exercised next to matching ones. Every one of the eight cluster tags can be used in random traffic. The local program store of 64 words is small enough to wrap the counter. It also holds a jump, a jump loop and a halt at fixed addresses, all of which are reached. A random phase mixes configure commands, switches in both directions and tagged broadcasts against a cycle-by-cycle reference model.

// File: rtl/elem_seq_pkg.sv
package elem_seq_pkg;
  localparam int GRP_W = 3;
  localparam logic [GRP_W-1:0] GRP_JUMP = 3'b011;
  localparam logic [GRP_W-1:0] GRP_SYS  = 3'b111;

  typedef struct packed {
    logic loadStart;
    logic jumpPc;
    logic stepPc;
    logic issueBc;
    logic issueLoc;
  } seq_strobe_t;
endpackage

// File: rtl/elem_seq_ctrl.sv
module elem_seq_ctrl
  import elem_seq_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int ELEM_ID = 0,
  parameter int CL_W    = 3,
  parameter int INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgValid,
  input  logic               cfgAll,
  input  logic [IDX_W-1:0]   cfgTarget,
  input  logic               cfgMimd,
  input  logic [CL_W-1:0]    cfgCluster,
  input  logic               bcValid,
  input  logic [CL_W-1:0]    bcCluster,
  input  logic [INSTR_W-1:0] lpmData,
  output seq_strobe_t        strobe,
  output logic               fetchOn,
  output logic               modeMimd,
  output logic [CL_W-1:0]    clusterId,
  output logic               doneFlag
);
  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(ELEM_ID);

  logic cfgHit;
  logic bcHit;
  logic [GRP_W-1:0] grp;
  logic isJump;
  logic isSys;

  assign cfgHit  = cfgValid && (cfgAll || cfgTarget == MY_IDX);
  assign fetchOn = modeMimd && !doneFlag;
  assign bcHit   = !modeMimd && bcValid && (bcCluster == clusterId);
  assign grp     = lpmData[INSTR_W-1 -: GRP_W];
  assign isJump  = fetchOn && (grp == GRP_JUMP);
  assign isSys   = fetchOn && (grp == GRP_SYS);

  always_comb begin
    strobe.loadStart = cfgHit && cfgMimd;
    strobe.jumpPc    = isJump && !strobe.loadStart;
    strobe.stepPc    = fetchOn && !isJump && !isSys && !strobe.loadStart;
    strobe.issueBc   = bcHit;
    strobe.issueLoc  = fetchOn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeMimd  <= 1'b0;
      clusterId <= '0;
      doneFlag  <= 1'b0;
    end else begin
      if (cfgHit) begin
        modeMimd  <= cfgMimd;
        clusterId <= cfgCluster;
        doneFlag  <= 1'b0;
      end else if (isSys) begin
        doneFlag  <= 1'b1;
      end
    end
  end

  // R6: a parked element stays parked until a configure command reaches it
  a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (doneFlag && !cfgHit) |=> doneFlag);

  // R6: a system-control word fetched locally parks the element
  a_r6_sys_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchOn && lpmData[INSTR_W-1 -: GRP_W] == GRP_SYS && !cfgValid) |=> doneFlag);

  // R11: a command that reaches the element loads cluster and mode
  a_r11_cfg_loads: assert property (@(posedge clk) disable iff (!rst_n)
    cfgHit |=> (clusterId == $past(cfgCluster) && modeMimd == $past(cfgMimd)));

  // R7: without a command for this element, mode and cluster stay put
  a_r7_no_hit_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgValid |=> ($stable(modeMimd) && $stable(clusterId)));
endmodule

// File: rtl/elem_seq_dp.sv
module elem_seq_dp
  import elem_seq_pkg::*;
#(
  parameter int PC_W    = 8,
  parameter int INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  seq_strobe_t        strobe,
  input  logic [PC_W-1:0]    cfgStart,
  input  logic [INSTR_W-1:0] bcInstr,
  input  logic [INSTR_W-1:0] lpmData,
  output logic [PC_W-1:0]    pc,
  output logic               issueValid,
  output logic [INSTR_W-1:0] issueInstr,
  output logic               issueLocal
);
  logic [PC_W-1:0]    pcNext;
  logic [INSTR_W-1:0] instrSel;

  always_comb begin
    if (strobe.loadStart)   pcNext = cfgStart;
    else if (strobe.jumpPc) pcNext = lpmData[PC_W-1:0];
    else if (strobe.stepPc) pcNext = pc + PC_W'(1);
    else                    pcNext = pc;
  end

  always_comb begin
    if (strobe.issueLoc)     instrSel = lpmData;
    else if (strobe.issueBc) instrSel = bcInstr;
    else                     instrSel = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc         <= '0;
      issueValid <= 1'b0;
      issueInstr <= '0;
      issueLocal <= 1'b0;
    end else begin
      pc         <= pcNext;
      issueValid <= strobe.issueLoc || strobe.issueBc;
      issueInstr <= instrSel;
      issueLocal <= strobe.issueLoc;
    end
  end

  // R9: a switch to independent mode loads the start address
  a_r9_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadStart |=> (pc == $past(cfgStart)));

  // R4: a plain local word advances the counter by one
  a_r4_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.stepPc |=> (pc == $past(pc) + PC_W'(1)));

  // R5: a jump word redirects the counter
  a_r5_jump: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.jumpPc |=> (pc == $past(lpmData[PC_W-1:0])));

  // R2: a matching broadcast appears one cycle later, marked as broadcast
  a_r2_bc_issue: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.issueBc |=> (issueValid && !issueLocal && issueInstr == $past(bcInstr)));
endmodule

// File: rtl/elem_seq_top.sv
module elem_seq_top
  import elem_seq_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int ELEM_ID = 0,
  parameter int CL_W    = 3,
  parameter int PC_W    = 8,
  parameter int INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgValid,
  input  logic               cfgAll,
  input  logic [IDX_W-1:0]   cfgTarget,
  input  logic               cfgMimd,
  input  logic [CL_W-1:0]    cfgCluster,
  input  logic [PC_W-1:0]    cfgStart,
  input  logic               bcValid,
  input  logic [CL_W-1:0]    bcCluster,
  input  logic [INSTR_W-1:0] bcInstr,
  output logic [PC_W-1:0]    lpmAddr,
  output logic               lpmRdEn,
  input  logic [INSTR_W-1:0] lpmData,
  output logic               issueValid,
  output logic [INSTR_W-1:0] issueInstr,
  output logic               issueLocal,
  output logic               doneFlag,
  output logic               modeMimd,
  output logic [CL_W-1:0]    clusterId
);
  seq_strobe_t strobe;
  logic        fetchOn;

  elem_seq_ctrl #(
    .IDX_W(IDX_W), .ELEM_ID(ELEM_ID), .CL_W(CL_W), .INSTR_W(INSTR_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfgValid(cfgValid), .cfgAll(cfgAll), .cfgTarget(cfgTarget),
    .cfgMimd(cfgMimd), .cfgCluster(cfgCluster),
    .bcValid(bcValid), .bcCluster(bcCluster), .lpmData(lpmData),
    .strobe(strobe), .fetchOn(fetchOn),
    .modeMimd(modeMimd), .clusterId(clusterId), .doneFlag(doneFlag)
  );

  elem_seq_dp #(
    .PC_W(PC_W), .INSTR_W(INSTR_W)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .cfgStart(cfgStart), .bcInstr(bcInstr), .lpmData(lpmData),
    .pc(lpmAddr), .issueValid(issueValid), .issueInstr(issueInstr),
    .issueLocal(issueLocal)
  );

  assign lpmRdEn = fetchOn;

  // R3: no broadcast-sourced issue follows a cycle spent in independent mode
  a_r3_mimd_ignores_bc: assert property (@(posedge clk) disable iff (!rst_n)
    modeMimd |=> !(issueValid && !issueLocal));

  // R10: a cycle spent in lockstep mode never produces a local issue
  a_r10_simd_no_local: assert property (@(posedge clk) disable iff (!rst_n)
    !modeMimd |=> !issueLocal);
endmodule

// File: tb/test_elem_seq_top.sv
module test_elem_seq_top;
  localparam int IDX_W = 4, ELEM_ID = 5, CL_W = 3, PC_W = 6, INSTR_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgValid = 0, cfgAll = 0, cfgMimd = 0, bcValid = 0;
  logic [IDX_W-1:0] cfgTarget = '0;
  logic [CL_W-1:0] cfgCluster = '0, bcCluster = '0;
  logic [PC_W-1:0] cfgStart = '0;
  logic [INSTR_W-1:0] bcInstr = '0;
  logic [PC_W-1:0] lpmAddr;
  logic lpmRdEn, issueValid, issueLocal, doneFlag, modeMimd;
  logic [INSTR_W-1:0] issueInstr, lpmData;
  logic [CL_W-1:0] clusterId;

  int total = 0, bad = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  // local program: 20 jumps to 30, 33 halts, 45 jumps back to 40
  function automatic logic [INSTR_W-1:0] memf(input logic [PC_W-1:0] a);
    if (a == 6'd20) return {3'b011, 7'd0, 6'd30};
    if (a == 6'd33) return {3'b111, 13'd0};
    if (a == 6'd45) return {3'b011, 7'd0, 6'd40};
    return {3'b001, 7'd5, a};
  endfunction

  assign lpmData = memf(lpmAddr);

  elem_seq_top #(.IDX_W(IDX_W), .ELEM_ID(ELEM_ID), .CL_W(CL_W), .PC_W(PC_W), .INSTR_W(INSTR_W))
  i_elem_seq_top (
    .clk(clk), .rst_n(rst_n), .cfgValid(cfgValid), .cfgAll(cfgAll), .cfgTarget(cfgTarget),
    .cfgMimd(cfgMimd), .cfgCluster(cfgCluster), .cfgStart(cfgStart),
    .bcValid(bcValid), .bcCluster(bcCluster), .bcInstr(bcInstr),
    .lpmAddr(lpmAddr), .lpmRdEn(lpmRdEn), .lpmData(lpmData),
    .issueValid(issueValid), .issueInstr(issueInstr), .issueLocal(issueLocal),
    .doneFlag(doneFlag), .modeMimd(modeMimd), .clusterId(clusterId));

  // reference model
  logic mMode = 0, mDone = 0, mIv = 0, mIl = 0;
  logic [CL_W-1:0] mCl = '0;
  logic [PC_W-1:0] mPc = '0;
  logic [INSTR_W-1:0] mIi = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mMode <= 0; mDone <= 0; mIv <= 0; mIl <= 0; mCl <= '0; mPc <= '0; mIi <= '0;
    end else begin
      automatic logic hit = cfgValid && (cfgAll || int'(cfgTarget) == ELEM_ID);
      automatic logic [INSTR_W-1:0] w = memf(mPc);
      automatic logic [PC_W-1:0] np = mPc;
      mIv <= 0; mIl <= 0; mIi <= '0;
      if (mMode && !mDone) begin
        mIv <= 1; mIl <= 1; mIi <= w;
        if (w[15:13] == 3'b011) np = w[PC_W-1:0];
        else if (w[15:13] == 3'b111) mDone <= 1;
        else np = mPc + 1;
      end else if (!mMode && bcValid && bcCluster == mCl) begin
        mIv <= 1; mIi <= bcInstr;
      end
      if (hit) begin
        mMode <= cfgMimd; mCl <= cfgCluster; mDone <= 0;
        if (cfgMimd) np = cfgStart;
      end
      mPc <= np;
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(issueValid == mIv, curReq, "issueValid", issueValid, mIv);
      chk(issueLocal == mIl, curReq, "issueLocal", issueLocal, mIl);
      chk(issueInstr == mIi, curReq, "issueInstr", issueInstr, mIi);
      chk(doneFlag == mDone, curReq, "doneFlag", doneFlag, mDone);
      chk(modeMimd == mMode, curReq, "modeMimd", modeMimd, mMode);
      chk(clusterId == mCl, curReq, "clusterId", clusterId, mCl);
      chk(lpmRdEn == (mMode && !mDone), curReq, "lpmRdEn", lpmRdEn, mMode && !mDone);
      if (mMode && !mDone) chk(lpmAddr == mPc, curReq, "lpmAddr", lpmAddr, mPc);
    end
  end

  task automatic idle();
    cfgValid = 0; bcValid = 0;
  endtask

  task automatic cfg(input logic all, input int tgt, input logic mimd,
                     input int cl, input int st);
    cfgValid = 1; cfgAll = all; cfgTarget = IDX_W'(tgt); cfgMimd = mimd;
    cfgCluster = CL_W'(cl); cfgStart = PC_W'(st);
  endtask

  task automatic bc(input int tag, input int w);
    bcValid = 1; bcCluster = CL_W'(tag); bcInstr = INSTR_W'(w);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    chk(!issueValid && !doneFlag && !modeMimd && clusterId == 0 && !lpmRdEn,
        "R1", "reset state", {issueValid, doneFlag, modeMimd, lpmRdEn}, 0);

    curReq = "R2";
    for (int i = 0; i < 4; i++) begin bc(0, 16'h1100 + i); cyc(1); end
    bc(0, 16'h2345); cyc(1); idle();
    chk(issueValid && !issueLocal && issueInstr == 16'h2345, "R2", "bc issue",
        issueInstr, 16'h2345);

    curReq = "R3";
    bc(3, 16'h7777); cyc(1); idle();
    chk(!issueValid, "R3", "mismatched tag", issueValid, 0);

    curReq = "R7";
    cfg(0, 7, 1, 4, 9); cyc(1); idle(); cyc(1);
    chk(!modeMimd && clusterId == 0, "R7", "other index ignored", modeMimd, 0);

    curReq = "R11";
    cfg(0, ELEM_ID, 0, 3, 0); cyc(1); bc(3, 16'h0abc); cfgValid = 0; cyc(1); idle();
    chk(clusterId == 3 && issueValid && issueInstr == 16'h0abc, "R11", "new tag used",
        issueInstr, 16'h0abc);
    bc(0, 16'h0def); cyc(1); idle();
    chk(!issueValid, "R11", "old tag dropped", issueValid, 0);

    curReq = "R8";
    cfg(1, 2, 1, 1, 18); cyc(1); idle();
    chk(modeMimd && lpmRdEn && lpmAddr == 18, "R9", "start loaded", lpmAddr, 18);
    curReq = "R5";
    cyc(3);
    chk(lpmAddr == 30, "R5", "jump target", lpmAddr, 30);
    curReq = "R6";
    bc(1, 16'h4444);
    cyc(5);
    chk(doneFlag && !lpmRdEn && !issueValid, "R6", "parked", {doneFlag, lpmRdEn, issueValid}, 3'b100);
    curReq = "R3"; cyc(3); idle();
    chk(!issueValid, "R3", "bc ignored in MIMD", issueValid, 0);

    curReq = "R9";
    cfg(0, ELEM_ID, 1, 1, 40); cyc(1); idle();
    chk(!doneFlag && lpmAddr == 40, "R9", "restart clears done", lpmAddr, 40);
    curReq = "R4"; cyc(15);

    curReq = "R10";
    cfg(0, ELEM_ID, 0, 2, 0); bc(2, 16'h5a5a); cyc(1); cfgValid = 0;
    chk(issueLocal && issueValid, "R10", "config cycle issues local", issueLocal, 1);
    cyc(1); idle();
    chk(!issueLocal && issueValid && issueInstr == 16'h5a5a && !lpmRdEn, "R10",
        "then broadcast", issueInstr, 16'h5a5a);

    curReq = "R4";
    for (int i = 0; i < 3000; i++) begin
      idle();
      if ($urandom_range(0, 19) == 0)
        cfg($urandom_range(0, 3) == 0, $urandom_range(4, 7), $urandom_range(0, 1),
            $urandom_range(0, 7), $urandom_range(0, 63));
      if ($urandom_range(0, 1) == 1) bc($urandom_range(0, 7), $urandom);
      cyc(1);
    end
    idle(); cyc(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule